// File: doc/BRIEF.md
# Command-Sequenced SPI Master

This block is an SPI master attached to a small word-wide register bus. Each trigger runs one command. A command always has a write phase. In the read mode, a read phase follows it without any further software action. Software sets the clock divisor and loads one or more transmit words into a shared data register. It then writes the command word, which carries the byte counts, the mode and the start bit.

The controller takes transmit bytes from a four-word FIFO, lowest byte first, and shifts each byte out MSB first in SPI mode 0. In the read phase it clocks in the requested number of bytes and packs them the same way into a four-word receive FIFO. Software drains that FIFO through the same data register. Chip select stays low for the whole command. A busy flag reports progress, and a full flag protects the transmit FIFO. A self-clearing reset bit aborts a command and empties both FIFOs.

Top module: `spi_cmd_master`

## Requirements
- R1: The SCLK high time and low time are each (BAUD+1) clock cycles, so one full period is 2*(BAUD+1) cycles. BAUD is bits 7:0 of the divisor register at address 1.
- R2: SPI mode 0. SCLK idles low. Each byte is shifted MSB first. MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R3: Transmit words are written to the data register at address 4. Byte 0 (bits 7:0) is sent first, then bits 15:8, and so on. A final partial word uses only its low bytes.
- R4: spi_cs_n goes low after a start and stays low until the command ends. While spi_cs_n is high, SCLK is low.
- R5: In write-then-read mode, the read phase starts without a second trigger and with chip select held low. MOSI is 0 during the read phase. Received bytes are packed into words lowest byte first, and the upper bytes of a final partial word are zero.
- R6: The command register is at address 2. Bits 7:0 hold the write length minus one and bits 15:8 hold the read length minus one. Bit 16 is the mode: 0 is write-only, 1 is write-then-read. Writing 1 to bit 24 starts a command. A read of the register returns the stored count and mode fields.
- R7: Status bit 0 (busy) at address 3 is 1 from the cycle after the start write. It clears one cycle after the last received byte is stored, or one cycle after the end of the last transmitted byte in write-only mode. A command-register write while busy is ignored.
- R8: Status bit 1 is 1 when the transmit FIFO holds four words. A data write while the FIFO is full is dropped.
- R9: A read of the data register with the receive FIFO empty returns 0 and changes no state.
- R10: Writing 1 to bit 0 of the control register at address 0 aborts any command and empties both FIFOs. Busy reads 0 and spi_cs_n is high afterwards. BAUD keeps its value.
- R11: In write-only mode, received data is discarded and the receive FIFO stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench uses a device model that records every MOSI bit on rising SCLK edges and returns a known, index-dependent byte pattern on MISO.

- A write-only command of three bytes spans a partial word. It checks byte order and the treatment of the unused top byte.
- A full sixteen-byte command confirms the FIFO depth and that the dropped fifth word never reaches the wire.
- A two-byte write followed by a five-byte read shows the following at once:
  - the shift from transmit to receive without a trigger;
  - the zero-padded partial receive word;
  - a single chip-select pulse.
- Period measurement at a non-zero divisor separates the (BAUD+1) formula from off-by-one variants.
- A repeated start while busy, a start with an empty FIFO followed by a soft reset, and reads of an empty receive FIFO cover the cases where an input must be ignored.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int IDX_W  = $clog2(BYTES);
  localparam int CNT_W  = 8;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_BAUD   = 3'd1;
  localparam logic [2:0] A_CMD    = 3'd2;
  localparam logic [2:0] A_STATUS = 3'd3;
  localparam logic [2:0] A_DATA   = 3'd4;

  localparam int F_WLEN  = 0;
  localparam int F_RLEN  = 8;
  localparam int F_MODE  = 16;
  localparam int F_START = 24;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_SHIFT, SQ_FINISH} sq_state_t;

  function automatic logic [7:0] pick_byte(logic [WORD_W-1:0] w, logic [IDX_W-1:0] i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(logic [WORD_W-1:0] w, logic [7:0] b,
                                                 logic [IDX_W-1:0] i);
    logic [WORD_W-1:0] r;
    r = w;
    r[8*i +: 8] = b;
    return r;
  endfunction

  function automatic logic [CNT_W:0] span_of(logic [CNT_W-1:0] field);
    return {1'b0, field} + {{CNT_W{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp      <= bump(wp);
      end
      if (do_pop) rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud,
  input  logic             go,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [7:0]       rx_byte,
  output logic             done
);
  logic             active;
  logic [DIV_W-1:0] hcnt;
  logic [2:0]       bits;
  logic [7:0]       sh;
  logic             tick;

  assign tick    = active && (hcnt == baud);
  assign mosi    = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      hcnt    <= '0;
      bits    <= '0;
      sh      <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        active <= 1'b1;
        sh     <= tx_byte;
        hcnt   <= '0;
        bits   <= '0;
        sclk   <= 1'b0;
      end else if (tick) begin
        hcnt <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bits == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bits <= bits + 1'b1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else if (active) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  sq_state_t         state;
  logic [DIV_W-1:0]  baud_q;
  logic              mode_q, rd_phase, last_q;
  logic [CNT_W-1:0]  wlen_q, rlen_q;
  logic [CNT_W:0]    left;
  logic [IDX_W-1:0]  tx_idx, rx_idx;
  logic [WORD_W-1:0] rx_asm, rx_word;

  logic srst, eng_rst, busy, start_req, cmd_wr;
  logic tx_wr_req, rx_rd_req, tx_push, tx_pop, rx_push, rx_pop;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [WORD_W-1:0] tx_head, rx_head;
  logic can_go, go, done;
  logic [7:0] go_byte, rx_byte;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[WORD_W-1:F_START+1], bus_wdata[F_START-1:F_MODE+1]};

  assign srst      = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
  assign eng_rst   = rst || srst;
  assign busy      = (state != SQ_IDLE);
  assign spi_cs_n  = !busy;
  assign cmd_wr    = bus_wr && (bus_addr == A_CMD) && !busy;
  assign start_req = cmd_wr && bus_wdata[F_START];
  assign tx_wr_req = bus_wr && (bus_addr == A_DATA);
  assign rx_rd_req = bus_rd && (bus_addr == A_DATA);
  assign tx_push   = tx_wr_req && !tx_full;
  assign rx_pop    = rx_rd_req && !rx_empty;

  assign can_go  = rd_phase ? !rx_full : !tx_empty;
  assign go      = (state == SQ_LOAD) && can_go;
  assign go_byte = rd_phase ? 8'h00 : pick_byte(tx_head, tx_idx);
  assign tx_pop  = go && !rd_phase && ((tx_idx == IDX_W'(BYTES - 1)) || (left == 1));
  assign rx_word = put_byte(rx_asm, rx_byte, rx_idx);
  assign rx_push = (state == SQ_SHIFT) && done && rd_phase
                   && ((rx_idx == IDX_W'(BYTES - 1)) || last_q);

  spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .clr(eng_rst), .push(tx_push), .din(bus_wdata), .pop(tx_pop),
    .head(tx_head), .full(tx_full), .empty(tx_empty));

  spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .clr(eng_rst), .push(rx_push), .din(rx_word), .pop(rx_pop),
    .head(rx_head), .full(rx_full), .empty(rx_empty));

  spi_bit_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(eng_rst), .baud(baud_q), .go(go), .tx_byte(go_byte),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx_byte), .done(done));

  always_ff @(posedge clk) begin
    if (rst) baud_q <= '0;
    else if (bus_wr && (bus_addr == A_BAUD)) baud_q <= bus_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (eng_rst) begin
      state    <= SQ_IDLE;
      mode_q   <= 1'b0;
      wlen_q   <= '0;
      rlen_q   <= '0;
      rd_phase <= 1'b0;
      last_q   <= 1'b0;
      left     <= '0;
      tx_idx   <= '0;
      rx_idx   <= '0;
      rx_asm   <= '0;
    end else begin
      if (cmd_wr) begin
        wlen_q <= bus_wdata[F_WLEN +: CNT_W];
        rlen_q <= bus_wdata[F_RLEN +: CNT_W];
        mode_q <= bus_wdata[F_MODE];
      end
      case (state)
        SQ_IDLE: if (start_req) begin
          state    <= SQ_LOAD;
          rd_phase <= 1'b0;
          left     <= span_of(bus_wdata[F_WLEN +: CNT_W]);
          tx_idx   <= '0;
          rx_idx   <= '0;
          rx_asm   <= '0;
        end
        SQ_LOAD: if (go) begin
          left   <= left - 1'b1;
          last_q <= (left == 1);
          if (!rd_phase) tx_idx <= tx_pop ? '0 : tx_idx + 1'b1;
          state  <= SQ_SHIFT;
        end
        SQ_SHIFT: if (done) begin
          if (rd_phase) begin
            rx_asm <= rx_push ? '0 : rx_word;
            rx_idx <= rx_push ? '0 : rx_idx + 1'b1;
          end
          if (!last_q) begin
            state <= SQ_LOAD;
          end else if (!rd_phase && mode_q) begin
            rd_phase <= 1'b1;
            left     <= span_of(rlen_q);
            state    <= SQ_LOAD;
          end else begin
            state <= SQ_FINISH;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_BAUD:   bus_rdata = WORD_W'(baud_q);
      A_CMD:    bus_rdata = {{(WORD_W-F_MODE-1){1'b0}}, mode_q, rlen_q, wlen_q};
      A_STATUS: bus_rdata = {{(WORD_W-2){1'b0}}, tx_full, busy};
      A_DATA:   bus_rdata = rx_empty ? '0 : rx_head;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        sclk,
  input logic        mosi,
  input logic        busy,
  input logic        start_req,
  input logic        tx_full,
  input logic        tx_wr_req,
  input logic        tx_pop,
  input logic        rx_rd_req,
  input logic        rx_empty,
  input logic [31:0] rdata
);
  // R4
  a_r4_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R2
  a_r2_mosi_stable_while_high: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));
  // R7
  a_r7_busy_only_after_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_req));
  // R8
  a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_wr_req && !tx_pop) |=> tx_full);
  // R9
  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rx_rd_req && rx_empty) |-> (rdata == 32'h0));
endmodule

bind spi_cmd_master spi_cmd_master_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .busy(busy), .start_req(start_req), .tx_full(tx_full), .tx_wr_req(tx_wr_req),
  .tx_pop(tx_pop), .rx_rd_req(rx_rd_req), .rx_empty(rx_empty), .rdata(bus_rdata));

// File: tb/test_spi_cmd_master.sv
`timescale 1ns/1ps
module test_spi_cmd_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_cmd_master i_spi_cmd_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  // device model
  int k = 0, cs_falls = 0;
  time t_r0 = 0, t_r1 = 0;
  logic [7:0] cap [32];

  function automatic logic [7:0] resp(int i);
    return 8'hA5 ^ 8'(i * 29);
  endfunction

  always @(negedge spi_cs_n) begin
    k = 0;
    cs_falls++;
    for (int i = 0; i < 32; i++) cap[i] = 8'h0;
    spi_miso = resp(0)[7];
  end
  always @(posedge spi_sclk) begin
    if (k == 0) t_r0 = $time;
    if (k == 1) t_r1 = $time;
    cap[(k / 8) % 32] = {cap[(k / 8) % 32][6:0], spi_mosi};
    k++;
  end
  always @(negedge spi_sclk) spi_miso = resp(k / 8)[7 - (k % 8)];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd3, s);
      if (s[0] == 1'b0) return;
    end
    chk("R7 busy never cleared", 32'h1, 32'h0);
  endtask

  function automatic logic [31:0] cmdw(int wl, int rl, bit mode, bit go);
    return {7'h0, go, 7'h0, mode, 8'(rl - 1), 8'(wl - 1)};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R4 cs_n after reset", 32'(spi_cs_n), 32'h1);
    chk("R2 sclk idle low", 32'(spi_sclk), 32'h0);
    rd(3'd3, v); chk("R7 status after reset", v, 32'h0);
    rd(3'd4, v); chk("R9 empty data read", v, 32'h0);
  endtask

  task automatic t_write_partial();
    logic [31:0] v;
    wr(3'd1, 32'd1);
    wr(3'd4, 32'hDD33_2211);
    wr(3'd2, cmdw(3, 1, 0, 1));
    rd(3'd3, v); chk("R7 busy after start", v & 32'h1, 32'h1);
    chk("R4 cs low during command", 32'(spi_cs_n), 32'h0);
    wait_idle();
    chk("R4 cs high after command", 32'(spi_cs_n), 32'h1);
    chk("R3 bit count", 32'(k), 32'd24);
    chk("R3 byte0", 32'(cap[0]), 32'h11);
    chk("R3 byte1", 32'(cap[1]), 32'h22);
    chk("R2 byte2 msb first", 32'(cap[2]), 32'h33);
    rd(3'd4, v); chk("R11 rx stays empty", v, 32'h0);
  endtask

  task automatic t_period();
    wr(3'd1, 32'd3);
    wr(3'd4, 32'h0000_0081);
    wr(3'd2, cmdw(1, 1, 0, 1));
    wait_idle();
    chk("R1 sclk period ns", 32'(t_r1 - t_r0), 32'd32);
    chk("R6 single byte", 32'(k), 32'd8);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    int f0;
    wr(3'd1, 32'd0);
    wr(3'd4, 32'h0000_C39A);
    f0 = cs_falls;
    wr(3'd2, cmdw(2, 5, 1, 1));
    wait_idle();
    chk("R5 one chip select pulse", 32'(cs_falls - f0), 32'd1);
    chk("R5 total bits", 32'(k), 32'd56);
    chk("R3 cmd byte0", 32'(cap[0]), 32'h9A);
    chk("R3 cmd byte1", 32'(cap[1]), 32'hC3);
    for (int i = 2; i < 7; i++) chk("R5 mosi zero in read", 32'(cap[i]), 32'h0);
    rd(3'd2, v); chk("R6 cmd readback", v, 32'h0001_0401);
    rd(3'd4, v); chk("R5 rx word0", v, {resp(5), resp(4), resp(3), resp(2)});
    rd(3'd4, v); chk("R5 rx word1 padded", v, {24'h0, resp(6)});
    rd(3'd4, v); chk("R9 drained read", v, 32'h0);
  endtask

  task automatic t_start_ignored();
    logic [31:0] v;
    wr(3'd4, 32'h0000_5A3C);
    wr(3'd2, cmdw(2, 1, 0, 1));
    wr(3'd2, cmdw(4, 3, 1, 1));
    wait_idle();
    chk("R7 restart ignored bits", 32'(k), 32'd16);
    rd(3'd2, v); chk("R7 cmd unchanged while busy", v, 32'h0000_0001);
  endtask

  task automatic t_full_and_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) wr(3'd4, 32'h0403_0201 + 32'(i) * 32'h1010_1010);
    rd(3'd3, v); chk("R8 full flag", v, 32'h2);
    wr(3'd4, 32'hEEEE_EEEE);
    wr(3'd2, cmdw(16, 1, 0, 1));
    wait_idle();
    for (int i = 0; i < 16; i++)
      chk("R8 sixteen bytes in order", 32'(cap[i]), 32'((i % 4) + 1 + 16 * (i / 4)));
    rd(3'd3, v); chk("R8 full cleared", v, 32'h0);
    wr(3'd1, 32'd2);
    wr(3'd2, cmdw(1, 1, 0, 1));
    repeat (60) @(negedge clk);
    rd(3'd3, v); chk("R8 dropped word not sent", v, 32'h1);
    wr(3'd0, 32'h1);
    rd(3'd3, v); chk("R10 busy cleared", v, 32'h0);
    chk("R10 cs high", 32'(spi_cs_n), 32'h1);
    rd(3'd1, v); chk("R10 baud kept", v, 32'd2);
    wr(3'd4, 32'h0000_0077);
    wr(3'd0, 32'h1);
    wr(3'd2, cmdw(1, 1, 0, 1));
    repeat (60) @(negedge clk);
    rd(3'd3, v); chk("R10 tx fifo emptied", v, 32'h1);
    wr(3'd0, 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_partial();
    t_period();
    t_write_read();
    t_start_ignored();
    t_full_and_reset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule